// File: doc/BRIEF.md
# Trapezoidal Energy Shaper with Pole-Zero Correction

This block turns a stream of signed samples from a charge-integrating preamplifier into a trapezoid-shaped waveform. From that waveform it takes a pulse-height value for each trigger. The rise and fall of the trapezoid share one programmable length, k samples. The flat top has its own length, m samples, which is set from the expected signal rise time so that slow charge collection does not reduce the measured height. A programmable pole-zero coefficient cancels the exponential decay tail of the preamplifier. A coefficient of zero stands for an infinite decay constant and turns the correction off.

The shaped value is computed from two delay-line differences (lengths k and k+m), a running sum, a pole-zero multiply-add and a final running sum. A baseline restorer then subtracts a slow running average from that value, so that the output settles at zero between pulses. The running average stops updating while a pulse is being processed.

A trigger strobe that arrives with a sample arms a capture counter. A fixed number of samples later, the block latches the baseline-corrected height into a 15-bit energy register and raises a one-cycle strobe. Samples are accepted only on cycles where the sample-valid input is high, which allows an 80 MHz sample stream on a faster clock.

Top module: `trap_shaper`

## Requirements
- R1: While reset is asserted, and after it until the first accepted sample, the shaped output is 0, the energy is 0 and energy_vld is low.
- R2: On a cycle with smp_vld low, the block ignores smp and trig: shaped and energy hold their values and energy_vld stays low.
- R3: With cfg_pz = 0, a step of height A (from a settled zero baseline) makes the shaped output rise by A per sample to k·A. It then holds k·A for m+1 samples and falls back to 0 over k samples.
- R4: For accepted sample n, d(n) = x(n) − x(n−k) − x(n−k−m) + x(n−2k−m), where samples from before reset count as 0. Then p(n) = p(n−1) + d(n), r(n) = d(n) + floor(p(n)·cfg_pz / 65536) and s(n) = s(n−1) + r(n). The configuration holds 1 ≤ k ≤ KMAX and 0 ≤ m ≤ MMAX.
- R5: A non-zero cfg_pz of about 65536/τ (τ in samples) cancels the decay tail of an exponential pulse with decay constant τ. A cfg_pz of 0 means no correction, which suits an infinite decay constant.
- R6: A trigger on accepted sample t makes energy_vld pulse for one cycle after accepted sample t + k + floor(m/2). The energy captured with it is s − b as it stood just before that sample. The energy is clipped to the range 0 to 32767.
- R7: A trigger that arrives while a capture is pending restarts the count, and the pending capture is dropped. A trigger on the capture sample itself still yields that capture and starts a new count.
- R8: After each accepted sample, the baseline b is updated as b += floor((s − b)/8), using the values from before that sample. The update is skipped on a trigger sample and for the next 4k + 2m accepted samples.
- R9: The shaped output is s − b saturated to the signed SW-bit range (−524288 to 524287 by default), and it is valid one clock after the sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample accepted this cycle |
| smp | input | DW | Signed sample |
| trig | input | 1 | Trigger strobe, qualified by smp_vld |
| cfg_rise | input | clog2(KMAX+1) | Rise and fall length k in samples |
| cfg_flat | input | clog2(MMAX+1) | Flat-top length m in samples |
| cfg_pz | input | CW | Pole-zero coefficient, 0 = infinite decay constant |
| shaped | output | SW | Baseline-corrected, saturated trapezoid |
| energy | output | EW | Captured pulse height |
| energy_vld | output | 1 | One-cycle strobe for energy |

## Verification
Two functions can land on the same accepted sample. A new trigger can arrive on the exact sample that completes a pending capture, and the bench drives a second trigger exactly k + floor(m/2) samples after the first to make this happen. That single sample must produce the pending energy strobe and must also start a fresh count whose capture appears the same distance later. The bench also checks that an earlier retrigger drops the pending capture. A reference model in the bench, built from the filter equations, compares every shaped value and every strobe sample by sample.

// File: rtl/trap_shaper.sv
module trap_shaper #(
  parameter int DW   = 16,
  parameter int KMAX = 32,
  parameter int MMAX = 32,
  parameter int AW   = 40,
  parameter int CW   = 16,
  parameter int PZF  = 16,
  parameter int BLS  = 3,
  parameter int SW   = 20,
  parameter int EW   = 15
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         smp_vld,
  input  logic signed [DW-1:0]         smp,
  input  logic                         trig,
  input  logic [$clog2(KMAX+1)-1:0]    cfg_rise,
  input  logic [$clog2(MMAX+1)-1:0]    cfg_flat,
  input  logic [CW-1:0]                cfg_pz,
  output logic signed [SW-1:0]         shaped,
  output logic [EW-1:0]                energy,
  output logic                         energy_vld
);
  localparam int DEPTH = 2*KMAX + MMAX;
  localparam int IW    = $clog2(DEPTH+1);
  localparam int EC    = $clog2(KMAX+MMAX+1);
  localparam int FZ    = $clog2(2*DEPTH+1);
  localparam int PW    = AW + CW + 1;
  localparam logic signed [AW-1:0] SMAX = {{(AW-SW+1){1'b0}}, {(SW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = ~SMAX;
  localparam logic signed [AW-1:0] EMAX = {{(AW-EW){1'b0}}, {EW{1'b1}}};

  logic signed [DW-1:0] hist [DEPTH];
  logic signed [AW-1:0] p, s, bl;
  logic [EC-1:0] ecnt;
  logic [FZ-1:0] fz;

  logic [IW-1:0] k, l;
  assign k = IW'(cfg_rise);
  assign l = k + IW'(cfg_flat);

  logic signed [DW+1:0] d;
  assign d = (DW+2)'(smp) - (DW+2)'(hist[k-1'b1]) - (DW+2)'(hist[l-1'b1])
           + (DW+2)'(hist[l+k-1'b1]);

  logic signed [AW-1:0] p_nxt, r, gap;
  logic signed [PW-1:0] prod;
  assign p_nxt = p + AW'(d);
  assign prod  = PW'(p_nxt) * PW'($signed({1'b0, cfg_pz}));
  assign r     = AW'(d) + AW'(prod >>> PZF);
  assign gap   = s - bl;

  logic frz;
  assign frz = trig || (fz != '0);

  assign shaped = (gap > SMAX) ? SW'(SMAX) : (gap < SMIN) ? SW'(SMIN) : SW'(gap);

  logic [EW-1:0] clip;
  assign clip = (gap < 0) ? '0 : (gap > EMAX) ? {EW{1'b1}} : EW'(gap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      p <= '0;
      s <= '0;
      bl <= '0;
      ecnt <= '0;
      fz <= '0;
      energy <= '0;
      energy_vld <= 1'b0;
    end else begin
      energy_vld <= 1'b0;
      if (smp_vld) begin
        hist[0] <= smp;
        for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
        p <= p_nxt;
        s <= s + r;
        if (!frz) bl <= bl + (gap >>> BLS);
        if (ecnt == EC'(1)) begin
          energy_vld <= 1'b1;
          energy <= clip;
        end
        if (trig) begin
          ecnt <= EC'(cfg_rise) + EC'(cfg_flat >> 1);
          fz <= FZ'({cfg_rise, 2'b00}) + FZ'({cfg_flat, 1'b0});
        end else begin
          if (ecnt != '0) ecnt <= ecnt - 1'b1;
          if (fz != '0) fz <= fz - 1'b1;
        end
      end
    end
  end
endmodule

module trap_shaper_chk #(
  parameter int KMAX = 32,
  parameter int MMAX = 32,
  parameter int SW   = 20,
  parameter int EW   = 15
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      smp_vld,
  input logic [$clog2(KMAX+1)-1:0] cfg_rise,
  input logic [$clog2(MMAX+1)-1:0] cfg_flat,
  input logic signed [SW-1:0]      shaped,
  input logic [EW-1:0]             energy,
  input logic                      energy_vld
);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(shaped));
  // R2
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    energy_vld |-> $past(smp_vld));
  // R6
  energy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !energy_vld |-> $stable(energy));
  // R4
  cfg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rise != '0) && (int'(cfg_rise) <= KMAX) && (int'(cfg_flat) <= MMAX));
endmodule

bind trap_shaper trap_shaper_chk #(.KMAX(KMAX), .MMAX(MMAX), .SW(SW), .EW(EW)) u_chk (.*);

// File: tb/test_trap_shaper.sv
module test_trap_shaper;
  localparam int SW = 20;
  localparam int EW = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [15:0] smp = '0;
  logic trig = 1'b0;
  logic [5:0] cfg_rise = 6'd4;
  logic [5:0] cfg_flat = 6'd4;
  logic [15:0] cfg_pz = '0;
  logic signed [SW-1:0] shaped;
  logic [EW-1:0] energy;
  logic energy_vld;

  always #5 clk = ~clk;

  trap_shaper i_trap_shaper (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp), .trig(trig),
    .cfg_rise(cfg_rise), .cfg_flat(cfg_flat), .cfg_pz(cfg_pz),
    .shaped(shaped), .energy(energy), .energy_vld(energy_vld));

  typedef struct {
    longint sh;
    bit     ev;
    longint en;
    string  tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int hx[$];
  longint mp = 0, ms = 0, mb = 0;
  int mk = 4, mm = 4, mc = 0;
  int ec = 0, fzc = 0;

  function automatic longint xh(int j);
    return (j < hx.size()) ? longint'(hx[j]) : 0;
  endfunction

  function automatic longint sat_s(longint v);
    if (v > 524287) return 524287;
    if (v < -524288) return -524288;
    return v;
  endfunction

  function automatic longint sat_e(longint v);
    if (v < 0) return 0;
    if (v > 32767) return 32767;
    return v;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(int x, bit t, string tag);
    exp_t e;
    longint d, pn, r;
    hx.push_front(x);
    d  = xh(0) - xh(mk) - xh(mk+mm) + xh(2*mk+mm);
    pn = mp + d;
    r  = d + ((pn * longint'(mc)) >>> 16);
    e.ev = (ec == 1);
    e.en = sat_e(ms - mb);
    if (!(t || fzc != 0)) mb = mb + ((ms - mb) >>> 3);
    ms = ms + r;
    mp = pn;
    if (t) begin
      ec = mk + mm/2;
      fzc = 4*mk + 2*mm;
    end else begin
      if (ec != 0) ec--;
      if (fzc != 0) fzc--;
    end
    e.sh = sat_s(ms - mb);
    e.tag = tag;
    @(negedge clk);
    smp = 16'(x);
    trig = t;
    smp_vld = 1'b1;
    q.push_back(e);
  endtask

  task automatic idle(bit t, int junk, string tag);
    exp_t e;
    e.ev = 1'b0;
    e.en = 0;
    e.sh = sat_s(ms - mb);
    e.tag = tag;
    @(negedge clk);
    smp = 16'(junk);
    trig = t;
    smp_vld = 1'b0;
    q.push_back(e);
  endtask

  task automatic setcfg(int nk, int nm, int nc);
    exp_t e;
    e.ev = 1'b0;
    e.en = 0;
    e.sh = sat_s(ms - mb);
    e.tag = "R4 cfg";
    @(negedge clk);
    smp_vld = 1'b0;
    trig = 1'b0;
    cfg_rise = 6'(nk);
    cfg_flat = 6'(nm);
    cfg_pz = 16'(nc);
    mk = nk; mm = nm; mc = nc;
    q.push_back(e);
  endtask

  task automatic run(int x, int n, string tag);
    for (int i = 0; i < n; i++) put(x, 1'b0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(longint'(shaped) == e.sh, {e.tag, " shaped"}, longint'(shaped), e.sh);
        if (e.ev || energy_vld) begin
          check(energy_vld == e.ev, {e.tag, " strobe"}, longint'(energy_vld), longint'(e.ev));
          if (e.ev && energy_vld)
            check(longint'(energy) == e.en, {e.tag, " energy"}, longint'(energy), e.en);
        end
      end else if (rst_n) begin
        check(!energy_vld, "R6 stray strobe", longint'(energy_vld), 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state while held
    check(shaped == 0, "R1 shaped in reset", longint'(shaped), 0);
    check(energy == 0, "R1 energy in reset", longint'(energy), 0);
    check(!energy_vld, "R1 strobe in reset", longint'(energy_vld), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(shaped == 0 && !energy_vld, "R1 after release", longint'(shaped), 0);

    // R3 step with infinite decay constant, k=4 m=4
    setcfg(4, 4, 0);
    run(0, 5, "R4 rest");
    put(1000, 1'b1, "R3 step");
    run(1000, 20, "R3 step");
    run(0, 30, "R3 fall");

    // R2 trig and samples ignored while smp_vld low
    for (int i = 0; i < 5; i++) idle(1'b1, 12345, "R2 idle");
    run(0, 3, "R2 after idle");

    // R7 retrigger and trigger on the capture sample, k=3 m=2 (window 4)
    setcfg(3, 2, 0);
    run(0, 20, "R7 rest");
    put(500, 1'b1, "R7 first");
    put(500, 1'b0, "R7 pend");
    put(500, 1'b1, "R7 retrig");
    run(500, 3, "R7 count");
    put(500, 1'b1, "R7 capture+rearm");
    run(500, 3, "R7 count2");
    put(500, 1'b0, "R7 second capture");
    run(500, 20, "R7 tail");
    run(0, 30, "R7 down");

    // R5 exponential tail with pole-zero correction, tau=16
    setcfg(4, 2, 4096);
    run(0, 10, "R5 rest");
    begin
      int x;
      x = 1600;
      put(x, 1'b1, "R5 pulse");
      for (int i = 0; i < 60; i++) begin
        x = x - (x >>> 4);
        put(x, 1'b0, "R5 decay");
      end
    end
    run(0, 40, "R5 rest2");

    // R8 over-corrected step leaves offset that the baseline removes
    put(100, 1'b1, "R8 step");
    run(100, 150, "R8 track");
    @(negedge clk);
    #1;
    check(shaped < 8 && shaped > -8, "R8 settled", longint'(shaped), 0);
    run(0, 150, "R8 down");

    // R9 saturation with k=32 m=0
    setcfg(32, 0, 0);
    run(0, 10, "R9 rest");
    put(30000, 1'b1, "R9 high");
    run(30000, 70, "R9 high");
    run(0, 70, "R9 low");
    run(0, 150, "R9 settle");

    // R6 negative capture clips to zero, k=2 m=2
    setcfg(2, 2, 0);
    run(0, 10, "R6 rest");
    put(-300, 1'b1, "R6 neg");
    run(-300, 20, "R6 neg");
    run(0, 40, "R6 back");

    // R6 shortest window k=1 m=0
    setcfg(1, 0, 0);
    run(0, 10, "R6 rest");
    put(777, 1'b1, "R6 short");
    run(777, 6, "R6 short");
    run(0, 10, "R6 tail");

    @(negedge clk);
    smp_vld = 1'b0;
    trig = 1'b0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R6 queue drained", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule